// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block holds three independent 16-bit down-counters. All three advance on a shared count-enable strobe that stands for the timer's fixed input tick. A host reaches them through a small byte-wide bus with a 2-bit address. Addresses 0, 1 and 2 are the data ports of channels 0 to 2, and address 3 is the control port. Control words pick a channel's operating mode, freeze its count for a stable read, or freeze the counts of several channels at once. Each channel is loaded with two byte writes and read back with two byte reads, low byte first.

Each channel drives an output level and a one-cycle interrupt pulse. It supports three operating modes:

- **One-shot:** counts the loaded value down once, then raises its output and stops.
- **Rate generator:** reloads itself and pulses at a fixed interval.
- **Square wave:** behaves like the rate generator and also flips its output on every expiry.

Some requests are not supported: decimal counting, single-byte access, other operating modes, and a status byte in the multi-channel freeze. These set a sticky error flag and change nothing else.

Top module: `pit_timer3`

## Requirements
- R1: After reset every channel is idle, with its output low and its interrupt low, no count frozen, and both byte pointers at the low byte. The error flag is low, and a count read returns 0.
- R2: A control word at address 3 is decoded by field. Bits 7:6 select channel 0-2, and the value 3 means the multi-channel freeze. Bits 5:4 are the access field, where 0 means freeze this channel's count and 3 means low-then-high byte access. Bits 3:1 are the mode: 0 is one-shot, 2 is rate generator, 3 is square wave. Bit 0 requests decimal counting.
- R3: Count writes alternate low byte then high byte. A low-byte write stops the channel and drives its output low. A high-byte write loads the 16-bit value and starts the channel from it.
- R4: In one-shot mode the period equals the loaded value N. After N count-enable cycles the output goes high and stays high, the channel stops, and one interrupt is issued.
- R5: In rate-generator and square-wave modes the period is N-1. The channel reloads itself on expiry and issues an interrupt every N-1 count-enable cycles.
- R6: In square-wave mode the output toggles on every expiry, starting low after the load. In rate-generator mode the output stays low.
- R7: The counter moves only on cycles where tick_en is high. Each expiry gives chan_irq a pulse lasting one clock, in the cycle after the clock edge that took the count to expiry.
- R8: A live count read returns the clocks left in one-shot mode and the clocks left plus 1 in the periodic modes. An idle channel reads 0. Bytes come low then high.
- R9: A freeze request captures the count and resets the read pointer to the low byte, but only if no frozen value is already held. Repeated requests are ignored until the high byte of the frozen value has been read, and that read releases it.
- R10: When the multi-channel freeze word has bit 5 low, every channel whose bit is set in bits 3:1 freezes its count (bit 1 is channel 0, bit 3 is channel 2). Bit 4 low asks for a status byte, which is not supported and sets the error flag.
- R11: A control word that requests an unsupported mode, decimal counting or a non-two-byte access sets a sticky error flag. It leaves that channel's mode unchanged, and only reset clears the flag.
- R12: A load whose period comes out as 0 never starts the channel. This covers one-shot with N=0 and the periodic modes with N=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Count enable; one high cycle is one timer input tick |
| bus_addr | input | 2 | 0-2 channel data ports, 3 control port |
| bus_wdata | input | 8 | Write data byte |
| bus_wr | input | 1 | Write strobe, one byte per high cycle |
| bus_rd | input | 1 | Read strobe; advances the addressed channel's read pointer |
| bus_rdata | output | 8 | Read data, valid in the same cycle as bus_rd, 0 otherwise |
| chan_out | output | 3 | Output level per channel |
| chan_irq | output | 3 | One-cycle interrupt pulse per channel |
| cfg_err | output | 1 | Sticky flag for unsupported control requests |

## Verification
Most internal faults show up at the ports within one period:

- A wrong reload value or a wrong off-by-one on the period shifts the spacing between interrupt pulses. It also shifts the live count read after a known number of ticks, and both appear on the first expiry.
- A corrupted byte pointer or frozen-count flag shows up on the next two-byte read. The bytes come back swapped, or they hold a live value where a frozen one was expected.
- A wrong square-wave toggle shows on chan_out after the first expiry.
- A control word that slipped through to change a channel is caught later. That channel then keeps or loses its periodic behaviour on the next load.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [1:0] {
    OPM_ONESHOT = 2'd0,
    OPM_RATE    = 2'd1,
    OPM_SQUARE  = 2'd2
  } opmode_e;

  localparam logic [1:0] SEL_MULTI  = 2'd3;
  localparam logic [1:0] ACC_FREEZE = 2'd0;
  localparam logic [1:0] ACC_WORD   = 2'd3;

  function automatic logic mode_supported(input logic [2:0] m);
    return (m == 3'd0) || (m == 3'd2) || (m == 3'd3);
  endfunction

  function automatic opmode_e mode_map(input logic [2:0] m);
    case (m)
      3'd2:    return OPM_RATE;
      3'd3:    return OPM_SQUARE;
      default: return OPM_ONESHOT;
    endcase
  endfunction

endpackage

// File: rtl/pit_rst_sync.sv
module pit_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/pit_ctrl_decode.sv
module pit_ctrl_decode
  import pit_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int BYTE_W = 8
) (
  input  logic              ctrl_wr,
  input  logic [BYTE_W-1:0] ctrl_word,
  output logic [NUM_CH-1:0] cfg_en,
  output logic [NUM_CH-1:0] latch_req,
  output opmode_e           cfg_mode,
  output logic              cfg_fault
);

  logic [1:0] sel;
  logic [1:0] acc;
  logic [2:0] md;
  logic       bcd;
  logic       mr_keep_count;   // multi-channel word: 1 = do not freeze counts
  logic       mr_keep_status;  // multi-channel word: 1 = no status byte asked
  logic [NUM_CH-1:0] sel_hit;
  logic [NUM_CH-1:0] mask_hit;

  assign sel            = ctrl_word[7:6];
  assign acc            = ctrl_word[5:4];
  assign md             = ctrl_word[3:1];
  assign bcd            = ctrl_word[0];
  assign mr_keep_count  = ctrl_word[5];
  assign mr_keep_status = ctrl_word[4];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
    assign sel_hit[i]  = (sel == 2'(i));
    assign mask_hit[i] = ctrl_word[1+i];
  end

  always_comb begin
    cfg_en    = '0;
    latch_req = '0;
    cfg_fault = 1'b0;
    cfg_mode  = mode_map(md);
    if (ctrl_wr) begin
      if (sel == SEL_MULTI) begin
        if (!mr_keep_count)  latch_req = mask_hit;
        if (!mr_keep_status) cfg_fault = 1'b1;
      end else if (acc == ACC_FREEZE) begin
        latch_req = sel_hit;
      end else if ((acc != ACC_WORD) || bcd || !mode_supported(md)) begin
        cfg_fault = 1'b1;
      end else begin
        cfg_en = sel_hit;
      end
    end
  end

endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              cfg_en,
  input  opmode_e           cfg_mode,
  input  logic              latch_req,
  input  logic              data_wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              data_rd,
  output logic [BYTE_W-1:0] rdata,
  output logic              out_lvl,
  output logic              irq_pulse
);

  localparam int LO_MSB = BYTE_W - 1;
  localparam int HI_LSB = BYTE_W;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  opmode_e          mode_q, mode_d;
  logic [CNT_W-1:0] init_q, init_d;
  logic [CNT_W-1:0] period_q, period_d;
  logic [CNT_W-1:0] remain_q, remain_d;
  logic             run_q, run_d;
  logic             out_q, out_d;
  logic             irq_q, irq_d;
  logic             frz_q, frz_d;
  logic [CNT_W-1:0] frz_val_q, frz_val_d;
  logic             rd_hi_q, rd_hi_d;
  logic             wr_hi_q, wr_hi_d;

  logic             periodic;
  logic [CNT_W-1:0] live_cnt;
  logic [CNT_W-1:0] shown_cnt;
  logic [CNT_W-1:0] new_init;
  logic [CNT_W-1:0] new_period;

  assign periodic = (mode_q != OPM_ONESHOT);

  always_comb begin
    if (!run_q)        live_cnt = '0;
    else if (periodic) live_cnt = remain_q + ONE;
    else               live_cnt = remain_q;
  end

  assign shown_cnt  = frz_q ? frz_val_q : live_cnt;
  assign rdata      = rd_hi_q ? shown_cnt[CNT_W-1:HI_LSB] : shown_cnt[LO_MSB:0];
  assign new_init   = {wdata, init_q[LO_MSB:0]};
  assign new_period = periodic ? (new_init - ONE) : new_init;

  always_comb begin
    mode_d    = mode_q;
    init_d    = init_q;
    period_d  = period_q;
    remain_d  = remain_q;
    run_d     = run_q;
    out_d     = out_q;
    irq_d     = 1'b0;
    frz_d     = frz_q;
    frz_val_d = frz_val_q;
    rd_hi_d   = rd_hi_q;
    wr_hi_d   = wr_hi_q;

    if (cfg_en) mode_d = cfg_mode;

    // counting engine, advanced only on count-enable cycles
    if (run_q && tick_en) begin
      if (remain_q == ONE) begin
        irq_d = 1'b1;
        if (periodic) begin
          remain_d = period_q;
          if (mode_q == OPM_SQUARE) out_d = ~out_q;
        end else begin
          out_d    = 1'b1;
          run_d    = 1'b0;
          remain_d = '0;
        end
      end else begin
        remain_d = remain_q - ONE;
      end
    end

    // count load: a bus write takes precedence over the engine
    if (data_wr) begin
      if (!wr_hi_q) begin
        init_d  = {init_q[CNT_W-1:HI_LSB], wdata};
        run_d   = 1'b0;
        out_d   = 1'b0;
        irq_d   = 1'b0;
        wr_hi_d = 1'b1;
      end else begin
        init_d   = new_init;
        period_d = new_period;
        wr_hi_d  = 1'b0;
        if (new_period != '0) begin
          run_d    = 1'b1;
          remain_d = new_period;
        end else begin
          run_d = 1'b0;
        end
      end
    end

    // read pointer and release of a frozen value
    if (data_rd) begin
      rd_hi_d = ~rd_hi_q;
      if (frz_q && rd_hi_q) frz_d = 1'b0;
    end

    // a freeze request wins over a read in the same cycle
    if (latch_req && !frz_q) begin
      frz_d     = 1'b1;
      frz_val_d = live_cnt;
      rd_hi_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= OPM_ONESHOT;
      init_q    <= '0;
      period_q  <= '0;
      remain_q  <= '0;
      run_q     <= 1'b0;
      out_q     <= 1'b0;
      irq_q     <= 1'b0;
      frz_q     <= 1'b0;
      frz_val_q <= '0;
      rd_hi_q   <= 1'b0;
      wr_hi_q   <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      init_q    <= init_d;
      period_q  <= period_d;
      remain_q  <= remain_d;
      run_q     <= run_d;
      out_q     <= out_d;
      irq_q     <= irq_d;
      frz_q     <= frz_d;
      frz_val_q <= frz_val_d;
      rd_hi_q   <= rd_hi_d;
      wr_hi_q   <= wr_hi_d;
    end
  end

  assign out_lvl   = out_q;
  assign irq_pulse = irq_q;

endmodule

// File: rtl/pit_timer3.sv
module pit_timer3
  import pit_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] chan_out,
  output logic [NUM_CH-1:0] chan_irq,
  output logic              cfg_err
);

  localparam int CNT_W = 2 * BYTE_W;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_CH);

  logic              rst_n_int;
  logic              ctrl_wr;
  logic [NUM_CH-1:0] cfg_en;
  logic [NUM_CH-1:0] latch_req;
  opmode_e           cfg_mode;
  logic              cfg_fault;
  logic              err_q, err_d;
  logic [BYTE_W-1:0] ch_rdata [NUM_CH];
  logic [NUM_CH-1:0] ch_sel;

  pit_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_int)
  );

  assign ctrl_wr = bus_wr && (bus_addr == CTRL_ADDR);

  pit_ctrl_decode #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_dec (
    .ctrl_wr   (ctrl_wr),
    .ctrl_word (bus_wdata),
    .cfg_en    (cfg_en),
    .latch_req (latch_req),
    .cfg_mode  (cfg_mode),
    .cfg_fault (cfg_fault)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign ch_sel[i] = (bus_addr == ADDR_W'(i));

    pit_channel #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n_int),
      .tick_en   (tick_en),
      .cfg_en    (cfg_en[i]),
      .cfg_mode  (cfg_mode),
      .latch_req (latch_req[i]),
      .data_wr   (bus_wr && ch_sel[i]),
      .wdata     (bus_wdata),
      .data_rd   (bus_rd && ch_sel[i]),
      .rdata     (ch_rdata[i]),
      .out_lvl   (chan_out[i]),
      .irq_pulse (chan_irq[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_rd && ch_sel[i]) bus_rdata = ch_rdata[i];
    end
  end

  assign err_d = err_q | cfg_fault;

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) err_q <= 1'b0;
    else            err_q <= err_d;
  end

  assign cfg_err = err_q;

endmodule

// File: rtl/pit_timer3_chk.sv
module pit_timer3_chk #(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [NUM_CH-1:0] chan_out,
  input logic [NUM_CH-1:0] chan_irq,
  input logic              cfg_err
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_CH);

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err); // R11

  AST_ERR_FROM_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> $past(bus_wr && (bus_addr == CTRL_ADDR))); // R11

  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !bus_wr) |=> $stable(chan_out)); // R3

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ast
    AST_IRQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      chan_irq[i] |-> $past(tick_en)); // R7

    AST_OUT_RISE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chan_out[i]) |-> chan_irq[i]); // R6
  end

endmodule

bind pit_timer3 pit_timer3_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_en  (tick_en),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .chan_out (chan_out),
  .chan_irq (chan_irq),
  .cfg_err  (cfg_err)
);

// File: tb/sim_pit_timer3.sv
module sim_pit_timer3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_en;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic       bus_wr;
  logic       bus_rd;
  logic [7:0] bus_rdata;
  logic [2:0] chan_out;
  logic [2:0] chan_irq;
  logic       cfg_err;

  int n_chk = 0;
  int n_fail = 0;
  int irq_cnt [3];

  always #4 clk = ~clk;

  pit_timer3 u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .chan_out(chan_out), .chan_irq(chan_irq),
    .cfg_err(cfg_err)
  );

  always @(negedge clk) begin
    if (rst_n) for (int i = 0; i < 3; i++) irq_cnt[i] += int'(chan_irq[i]);
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clr_irq();
    for (int i = 0; i < 3; i++) irq_cnt[i] = 0;
  endtask

  task automatic settle();
    @(negedge clk); #2;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1 bus_wr = 1'b0;
  endtask

  task automatic rd_byte(input logic [1:0] a, output logic [7:0] b);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 b = bus_rdata;
    @(posedge clk); #1 bus_rd = 1'b0;
  endtask

  task automatic rd_count(input logic [1:0] ch, output int v);
    logic [7:0] lo, hi;
    rd_byte(ch, lo);
    rd_byte(ch, hi);
    v = int'({hi, lo});
  endtask

  task automatic load(input logic [1:0] ch, input int md, input int n);
    wr(2'd3, {ch, 2'b11, 3'(md), 1'b0});
    wr(ch, 8'(n));
    wr(ch, 8'(n >> 8));
  endtask

  task automatic run_ticks(input int n, input bit gated);
    int got = 0;
    while (got < n) begin
      @(negedge clk);
      tick_en = gated ? 1'($urandom_range(0, 1)) : 1'b1;
      @(posedge clk);
      if (tick_en) got++;
      #1 tick_en = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  function automatic int exp_irqs(input int md, input int n, input int t);
    int p;
    if (md == 0) return (n > 0 && t >= n) ? 1 : 0;
    p = n - 1;
    return (p > 0) ? t / p : 0;
  endfunction

  function automatic int exp_count(input int md, input int n, input int t);
    int p;
    if (md == 0) return (n == 0 || t >= n) ? 0 : n - t;
    p = n - 1;
    return (p > 0) ? (p - t % p) + 1 : 0;
  endfunction

  function automatic int exp_out(input int md, input int n, input int t);
    if (md == 0) return exp_irqs(md, n, t);
    if (md == 3) return exp_irqs(md, n, t) % 2;
    return 0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int v, v1, v2, r1, r2, o, k;
    logic [7:0] b;
    void'($urandom(32'd2024));
    rst_n = 1'b0; tick_en = 1'b0; bus_addr = '0; bus_wdata = '0;
    bus_wr = 1'b0; bus_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 out", int'(chan_out), 0);
    chk("R1 irq", int'(chan_irq), 0);
    chk("R1 err", int'(cfg_err), 0);
    rd_count(2'd0, v); chk("R1 idle read ch0", v, 0);
    rd_count(2'd2, v); chk("R1 idle read ch2", v, 0);

    // R4 / R8 one-shot on ch0, N=5
    load(2'd0, 0, 5); clr_irq();
    rd_count(2'd0, v); chk("R8 one-shot initial read", v, 5);
    run_ticks(3, 0);
    rd_count(2'd0, v); chk("R8 one-shot after 3", v, 2);
    run_ticks(2, 0); settle();
    chk("R7 one-shot irq", irq_cnt[0], 1);
    chk("R4 one-shot out high", int'(chan_out[0]), 1);
    rd_count(2'd0, v); chk("R8 expired reads 0", v, 0);
    run_ticks(5, 0); settle();
    chk("R4 out stays high", int'(chan_out[0]), 1);
    chk("R4 no second irq", irq_cnt[0], 1);

    // R3 low-byte write clears output and stops channel
    wr(2'd0, 8'd9); settle();
    chk("R3 low byte drives out low", int'(chan_out[0]), 0);
    wr(2'd0, 8'd0);
    run_ticks(4, 0);
    rd_count(2'd0, v); chk("R3 high byte starts", v, 5);
    wr(2'd0, 8'd3);
    rd_count(2'd0, v); chk("R3 low byte stops", v, 0);
    run_ticks(10, 0); settle();
    chk("R3 stopped no irq", irq_cnt[0], 1);
    wr(2'd0, 8'd0);

    // R5 rate generator on ch1, N=4 -> period 3
    load(2'd1, 2, 4); clr_irq();
    rd_count(2'd1, v); chk("R8 rate initial read", v, 4);
    run_ticks(1, 0);
    rd_count(2'd1, v); chk("R8 rate after 1", v, 3);
    run_ticks(2, 0); settle();
    chk("R5 first expiry", irq_cnt[1], 1);
    rd_count(2'd1, v); chk("R5 reload", v, 4);
    run_ticks(6, 0); settle();
    chk("R5 repeated irq", irq_cnt[1], 3);
    chk("R6 rate out low", int'(chan_out[1]), 0);

    // R9 freeze once, pointer reset, release on high byte
    rd_byte(2'd1, b); chk("R9 live low byte", int'(b), 4);
    wr(2'd3, 8'h40);
    run_ticks(1, 0);
    wr(2'd3, 8'h40);
    rd_count(2'd1, v); chk("R9 frozen value", v, 4);
    rd_count(2'd1, v); chk("R9 released live", v, 3);

    // R6 square wave on ch2, N=6 -> period 5
    load(2'd2, 3, 6); clr_irq();
    run_ticks(5, 0); settle();
    chk("R6 square irq 1", irq_cnt[2], 1);
    chk("R6 square out high", int'(chan_out[2]), 1);
    run_ticks(5, 0); settle();
    chk("R6 square out low", int'(chan_out[2]), 0);

    // R10 multi-channel freeze of ch1 and ch2
    rd_count(2'd1, v1); rd_count(2'd2, v2);
    wr(2'd3, 8'hDC);
    run_ticks(2, 0);
    rd_count(2'd1, r1); chk("R10 ch1 frozen", r1, v1);
    rd_count(2'd2, r2); chk("R10 ch2 frozen", r2, v2);
    chk("R10 no status no err", int'(cfg_err), 0);

    // R11 unsupported mode leaves ch2 periodic
    wr(2'd3, 8'hB2); settle();
    chk("R11 bad mode err", int'(cfg_err), 1);
    k = irq_cnt[2]; o = int'(chan_out[2]);
    run_ticks(5, 0); settle();
    chk("R11 ch2 still periodic", irq_cnt[2], k + 1);
    chk("R11 ch2 still toggles", int'(chan_out[2]), 1 - o);

    // R11 decimal request: mode stays one-shot
    do_reset();
    chk("R1 err cleared by reset", int'(cfg_err), 0);
    wr(2'd3, 8'hB7); settle();
    chk("R11 bcd err", int'(cfg_err), 1);
    wr(2'd2, 8'd4); wr(2'd2, 8'd0); clr_irq();
    run_ticks(12, 0); settle();
    chk("R11 mode unchanged one irq", irq_cnt[2], 1);
    chk("R11 mode unchanged out", int'(chan_out[2]), 1);

    // R10 status request flags error, count freeze still applies
    do_reset();
    load(2'd0, 0, 20);
    run_ticks(3, 0);
    wr(2'd3, 8'hC2);
    run_ticks(4, 0);
    rd_count(2'd0, v); chk("R10 freeze with status", v, 17);
    chk("R10 status err", int'(cfg_err), 1);

    // R12 zero period
    do_reset();
    load(2'd0, 2, 1); clr_irq();
    rd_count(2'd0, v); chk("R12 rate N=1 idle", v, 0);
    run_ticks(5, 0); settle();
    chk("R12 rate N=1 no irq", irq_cnt[0], 0);
    load(2'd0, 0, 0);
    rd_count(2'd0, v); chk("R12 one-shot N=0 idle", v, 0);
    run_ticks(3, 0); settle();
    chk("R12 one-shot N=0 out low", int'(chan_out[0]), 0);

    // random mode / count / gated ticks on ch1
    for (int it = 0; it < 30; it++) begin
      int md, n, t, sel;
      sel = $urandom_range(0, 2);
      md = (sel == 0) ? 0 : sel + 1;
      n = (md == 0) ? $urandom_range(1, 60) : $urandom_range(2, 40);
      t = $urandom_range(0, 90);
      load(2'd1, md, n); clr_irq();
      run_ticks(t, 1); settle();
      rd_count(2'd1, v);
      chk("R8 random count", v, exp_count(md, n, t));
      chk("R5 random irqs", irq_cnt[1], exp_irqs(md, n, t));
      chk("R6 random out", int'(chan_out[1]), exp_out(md, n, t));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule